// File: doc/BRIEF.md
# Parallel Port Pattern-Match Detector

This block watches an 8-bit asynchronous input port and reports when the port takes on a programmed pattern. Three per-bit configuration vectors set what each bit must show: a mask that says whether the bit takes part, a polarity, and a transition select. With the transition select clear, the bit must hold a level. With it set, the bit must make an edge.

A 2-bit mode selects how the per-bit results combine. The modes are off, all-of (AND), any-of (OR), and any-of with a priority index. The first two combining modes raise a sticky pending request when the combined match begins. The priority mode keeps the request equal to the match level. It also presents the number of the highest matching bit, which lets an interrupt handler branch on the bit without polling.

The port inputs first pass through a two-stage synchronizer. A further stage keeps the previous sample so that edges can be found.

Top module: `pattern_match_unit`

## Requirements
- R1: A change on `pinIn` shows on `matchFlag` at the third rising clock edge after it is applied, and not at the second.
- R2: A bit with `patMask` = 0 never affects the combined match.
- R3: An enabled bit with `patTransition` = 0 matches while its synchronized level equals its `patPolarity` bit.
- R4: An enabled bit with `patTransition` = 1 matches for one cycle on a rising edge when `patPolarity` = 1, and on a falling edge when `patPolarity` = 0.
- R5: With `patMode` = 2'b01 (AND), the combined match needs every enabled bit to match and at least one bit enabled. With all mask bits 0 there is never a match.
- R6: With `patMode` = 2'b10 (OR), any one enabled bit matching is enough.
- R7: In the AND and OR modes, `irqPend` is set only on a cycle where the combined match goes from false to true. It stays set until `pendClr` is seen, and a new match start wins over a clear in the same cycle.
- R8: With `patMode` = 2'b11 (priority) and `latchedMode` = 0, `irqPend` follows the combined match level, and `pendClr` has no effect.
- R9: In priority mode, `matchIdx` gives the number of the highest-numbered matching bit. In every other mode, or when nothing matches, it reads 0.
- R10: Priority mode with `latchedMode` = 1 is not allowed and gives no match, no pending request and an index of 0.
- R11: With `patMode` = 2'b00 the block is off: `matchFlag` and `irqPend` read 0, and any pending request is dropped.
- R12: While `rstN` is low, `matchFlag`, `irqPend` and `matchIdx` all read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| pinIn | input | 8 | Asynchronous port input bits |
| patPolarity | input | 8 | Per-bit level or edge direction |
| patTransition | input | 8 | Per-bit select: 1 = edge, 0 = level |
| patMask | input | 8 | Per-bit enable: 1 = the bit takes part |
| patMode | input | 2 | 00 off, 01 AND, 10 OR, 11 priority |
| latchedMode | input | 1 | Port is in latched mode (this forbids priority mode) |
| pendClr | input | 1 | Clears the pending request in the AND and OR modes |
| matchFlag | output | 1 | Registered combined match level |
| irqPend | output | 1 | Interrupt-pending request |
| matchIdx | output | 3 | Highest matching bit number (priority mode) |

## Verification
The bench targets the AND mode with no bit enabled. A design that treats an empty AND as true would report a match on every cycle. A pattern that already matches when the bench clears the request and goes on matching must not raise a new request; level-set logic would raise one again. The bench also checks that a falling edge is not taken for a rising one, and that the index is the highest matching bit and not the lowest. It checks that the clear input is ignored in priority mode, and that latched mode blocks priority matching. Finally, it checks the exact three-edge latency, which catches a missing or an extra synchronizer stage.

// File: rtl/pm_pkg.sv
package pm_pkg;
  typedef enum logic [1:0] {
    PM_OFF  = 2'b00,
    PM_AND  = 2'b01,
    PM_OR   = 2'b10,
    PM_PRIO = 2'b11
  } pmMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic vecLoad;   // capture highest-bit index this cycle
  } pmStrobe_t;
endpackage

// File: rtl/pm_datapath.sv
module pm_datapath
  import pm_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int IDXW  = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] pinAsync,
  input  logic [WIDTH-1:0] polarity,
  input  logic [WIDTH-1:0] transition,
  input  logic [WIDTH-1:0] mask,
  input  pmStrobe_t        strobe,
  output logic             allHit,
  output logic             anyHit,
  output logic             anyEnabled,
  output logic [IDXW-1:0]  vecIdx
);
  logic [WIDTH-1:0] syncA, syncB, prevQ;
  logic [WIDTH-1:0] bitHit;
  logic [IDXW-1:0]  hiIdx;

  // two-flop synchronizer plus history stage for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      prevQ <= '0;
    end else begin
      syncA <= pinAsync;
      syncB <= syncA;
      prevQ <= syncB;
    end
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic levelOk, riseOk, fallOk, edgeOk;
    assign levelOk   = (syncB[i] == polarity[i]);
    assign riseOk    = syncB[i] & ~prevQ[i];
    assign fallOk    = ~syncB[i] & prevQ[i];
    assign edgeOk    = polarity[i] ? riseOk : fallOk;
    assign bitHit[i] = mask[i] & (transition[i] ? edgeOk : levelOk);
  end

  assign allHit     = &(bitHit | ~mask);
  assign anyHit     = |bitHit;
  assign anyEnabled = |mask;

  always_comb begin
    hiIdx = '0;
    for (int i = 0; i < WIDTH; i++) begin
      if (bitHit[i]) hiIdx = IDXW'(i);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               vecIdx <= '0;
    else if (strobe.vecLoad) vecIdx <= hiIdx;
    else                     vecIdx <= '0;
  end
endmodule

// File: rtl/pm_control.sv
module pm_control
  import pm_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic [1:0] modeSel,
  input  logic      latched,
  input  logic      clrReq,
  input  logic      allHit,
  input  logic      anyHit,
  input  logic      anyEnabled,
  output logic      flagQ,
  output logic      pendQ,
  output pmStrobe_t strobe
);
  pmMode_e mode;
  logic    prioActive;
  logic    combined;

  assign mode       = pmMode_e'(modeSel);
  assign prioActive = (mode == PM_PRIO) && !latched;

  always_comb begin
    unique case (mode)
      PM_AND:  combined = anyEnabled && allHit;
      PM_OR:   combined = anyHit;
      PM_PRIO: combined = prioActive && anyHit;
      default: combined = 1'b0;
    endcase
  end

  assign strobe.vecLoad = prioActive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ <= 1'b0;
      pendQ <= 1'b0;
    end else begin
      flagQ <= combined;
      unique case (mode)
        PM_OFF:  pendQ <= 1'b0;
        PM_PRIO: pendQ <= combined;
        default: begin
          if (combined && !flagQ) pendQ <= 1'b1;
          else if (clrReq)        pendQ <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/pattern_match_unit.sv
module pattern_match_unit
  import pm_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int IDXW  = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] pinIn,
  input  logic [WIDTH-1:0] patPolarity,
  input  logic [WIDTH-1:0] patTransition,
  input  logic [WIDTH-1:0] patMask,
  input  logic [1:0]       patMode,
  input  logic             latchedMode,
  input  logic             pendClr,
  output logic             matchFlag,
  output logic             irqPend,
  output logic [IDXW-1:0]  matchIdx
);
  pmStrobe_t strobe;
  logic      allHit, anyHit, anyEnabled;

  pm_datapath #(.WIDTH(WIDTH), .IDXW(IDXW)) u_dp (
    .clk(clk), .rstN(rstN), .pinAsync(pinIn),
    .polarity(patPolarity), .transition(patTransition), .mask(patMask),
    .strobe(strobe), .allHit(allHit), .anyHit(anyHit),
    .anyEnabled(anyEnabled), .vecIdx(matchIdx)
  );

  pm_control u_ctl (
    .clk(clk), .rstN(rstN), .modeSel(patMode), .latched(latchedMode),
    .clrReq(pendClr), .allHit(allHit), .anyHit(anyHit),
    .anyEnabled(anyEnabled), .flagQ(matchFlag), .pendQ(irqPend),
    .strobe(strobe)
  );
endmodule

// File: rtl/pm_checker.sv
module pm_checker #(
  parameter int IDXW = 3
) (
  input logic            clk,
  input logic            rstN,
  input logic [1:0]      patMode,
  input logic            latchedMode,
  input logic            pendClr,
  input logic            matchFlag,
  input logic            irqPend,
  input logic [IDXW-1:0] matchIdx
);
  // R7: in the edge-started modes a new request comes only with a match start
  p_pend_on_start_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(patMode) inside {2'b01, 2'b10}) && $rose(irqPend) |-> $rose(matchFlag));

  // R7: a clear with no match start drops the request
  p_clear_works_r7: assert property (@(posedge clk) disable iff (!rstN)
    $past(pendClr) && ($past(patMode) inside {2'b01, 2'b10}) && !$rose(matchFlag) |-> !irqPend);

  // R8: in priority mode the request tracks the match level
  p_level_follow_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(patMode) == 2'b11) && !$past(latchedMode) |-> irqPend == matchFlag);

  // R9: a nonzero index only comes with a match
  p_idx_needs_match_r9: assert property (@(posedge clk) disable iff (!rstN)
    (matchIdx != '0) |-> matchFlag);

  // R10: latched mode blocks priority matching
  p_latched_block_r10: assert property (@(posedge clk) disable iff (!rstN)
    ($past(patMode) == 2'b11) && $past(latchedMode) |-> !matchFlag && !irqPend && matchIdx == '0);

  // R11: the off mode keeps both flags low
  p_off_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    ($past(patMode) == 2'b00) |-> !matchFlag && !irqPend);

  // R12: reset values
  always @(negedge clk) begin
    if (!rstN) begin
      p_reset_vals_r12: assert (!matchFlag && !irqPend && matchIdx == '0);
    end
  end
endmodule

bind pattern_match_unit pm_checker #(.IDXW(IDXW)) u_chk (
  .clk(clk), .rstN(rstN), .patMode(patMode), .latchedMode(latchedMode),
  .pendClr(pendClr), .matchFlag(matchFlag), .irqPend(irqPend),
  .matchIdx(matchIdx)
);

// File: tb/sim_pattern_match_unit.sv
`timescale 1ns/1ps
module sim_pattern_match_unit;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] pinIn = '0, patPolarity = '0, patTransition = '0, patMask = '0;
  logic [1:0] patMode = '0;
  logic       latchedMode = 1'b0, pendClr = 1'b0;
  logic       matchFlag, irqPend;
  logic [2:0] matchIdx;
  int nChecks = 0, nErr = 0;

  always #2 clk = ~clk;

  pattern_match_unit u0 (.*);

  typedef struct packed {
    logic [7:0] pol, tr, mk;
    logic [1:0] md;
    logic       lat;
    logic [7:0] oldP, newP;
    logic       eFlag, ePend;
    logic [2:0] eVec;
    logic [7:0] req;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t TABLE [NV] = '{
    '{8'hA5, 8'h00, 8'hFF, 2'b01, 1'b0, 8'h00, 8'hA5, 1'b1, 1'b1, 3'd0, 8'd3}, // R3 AND levels
    '{8'h05, 8'h00, 8'h0F, 2'b01, 1'b0, 8'h00, 8'hF5, 1'b1, 1'b1, 3'd0, 8'd2}, // R2 upper bits masked
    '{8'hFF, 8'h00, 8'hFF, 2'b01, 1'b0, 8'h00, 8'h7F, 1'b0, 1'b0, 3'd0, 8'd5}, // R5 one bit short
    '{8'hFF, 8'h00, 8'h00, 2'b01, 1'b0, 8'h00, 8'hFF, 1'b0, 1'b0, 3'd0, 8'd5}, // R5 empty AND
    '{8'hFF, 8'h00, 8'h0F, 2'b10, 1'b0, 8'h00, 8'h04, 1'b1, 1'b1, 3'd0, 8'd6}, // R6 OR one bit
    '{8'h01, 8'h01, 8'h01, 2'b10, 1'b0, 8'h00, 8'h01, 1'b1, 1'b1, 3'd0, 8'd4}, // R4 rising
    '{8'h01, 8'h01, 8'h01, 2'b10, 1'b0, 8'h01, 8'h00, 1'b0, 1'b0, 3'd0, 8'd4}, // R4 fall vs rise
    '{8'h00, 8'h01, 8'h01, 2'b10, 1'b0, 8'h01, 8'h00, 1'b1, 1'b1, 3'd0, 8'd4}, // R4 falling
    '{8'hFF, 8'h00, 8'h03, 2'b10, 1'b0, 8'h01, 8'h03, 1'b1, 1'b0, 3'd0, 8'd7}, // R7 no new start
    '{8'hFF, 8'h00, 8'hFF, 2'b11, 1'b0, 8'h00, 8'h26, 1'b1, 1'b1, 3'd5, 8'd9}, // R9 highest bit
    '{8'hFF, 8'h00, 8'hFF, 2'b11, 1'b0, 8'h00, 8'h01, 1'b1, 1'b1, 3'd0, 8'd9}, // R9 bit zero
    '{8'hFF, 8'h00, 8'hFF, 2'b11, 1'b1, 8'h00, 8'hFF, 1'b0, 1'b0, 3'd0, 8'd10},// R10 latched
    '{8'hFF, 8'h00, 8'hFF, 2'b00, 1'b0, 8'h00, 8'hFF, 1'b0, 1'b0, 3'd0, 8'd11},// R11 off
    '{8'hFF, 8'h00, 8'hFF, 2'b10, 1'b0, 8'h00, 8'h80, 1'b1, 1'b1, 3'd0, 8'd9}, // R9 OR index 0
    '{8'hFF, 8'h00, 8'h0F, 2'b11, 1'b0, 8'h00, 8'hF3, 1'b1, 1'b1, 3'd1, 8'd9}  // R9 masked high bits
  };

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulseClr();
    @(negedge clk) pendClr = 1'b1;
    @(negedge clk) pendClr = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    // R12: reset state
    pinIn = 8'hFF; patMask = 8'hFF; patPolarity = 8'hFF; patMode = 2'b10;
    settle(4);
    chk("R12 flag", matchFlag, 0);
    chk("R12 pend", irqPend, 0);
    chk("R12 idx", matchIdx, 0);
    rstN = 1'b1;
    settle(2);

    for (int k = 0; k < NV; k++) begin
      vec_t v = TABLE[k];
      patPolarity = v.pol; patTransition = v.tr; patMask = v.mk;
      patMode = v.md; latchedMode = v.lat; pinIn = v.oldP;
      settle(6);
      pulseClr();
      pinIn = v.newP;
      settle(3);
      chk($sformatf("R%0d flag row%0d", v.req, k), matchFlag, v.eFlag);
      chk($sformatf("R%0d pend row%0d", v.req, k), irqPend, v.ePend);
      chk($sformatf("R%0d idx row%0d", v.req, k), matchIdx, v.eVec);
    end

    // R1: exact latency
    patPolarity = 8'hFF; patTransition = 8'h00; patMask = 8'hFF;
    patMode = 2'b10; latchedMode = 1'b0; pinIn = 8'h00;
    settle(6);
    pulseClr();
    pinIn = 8'h01;
    settle(2);
    chk("R1 early", matchFlag, 0);
    settle(1);
    chk("R1 on time", matchFlag, 1);

    // R7: request holds after the match ends, then clears
    pinIn = 8'h00;
    settle(5);
    chk("R7 flag gone", matchFlag, 0);
    chk("R7 pend held", irqPend, 1);
    pulseClr();
    chk("R7 pend cleared", irqPend, 0);

    // R8: priority level request ignores clear
    patMode = 2'b11; pinIn = 8'hFF;
    settle(5);
    chk("R8 pend level", irqPend, 1);
    pulseClr();
    chk("R8 clear ignored", irqPend, 1);
    pinIn = 8'h00;
    settle(3);
    chk("R8 pend follows low", irqPend, 0);

    // R11: off mode drops a pending request
    patMode = 2'b10; pinIn = 8'h01;
    settle(5);
    chk("R11 pend before", irqPend, 1);
    patMode = 2'b00;
    settle(1);
    chk("R11 pend dropped", irqPend, 0);

    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule